// File: doc/BRIEF.md
# Vector Sub-Element Loop Sequencer

This block holds the iteration state of a vector instruction whose elements are themselves short sub-vectors of one to four parts. It keeps a source element index, a destination element index and an inner sub-element index. Each advance request walks the indices in nested order: the inner sub-element index counts from zero up to the programmed sub-vector bound, and only when it wraps do the outer source and destination indices move. The outer indices can be frozen one by one by a hold input, so that a side that has already reached its final element stays there while the other side catches up.

The block also watches for the last iteration of the loop. It raises a flag while the loop sits on its final step, and the advance taken in that state returns all three indices to zero for the next instruction. A zero vector length in vector mode means the instruction does nothing: the block asks for it to be skipped and ignores advance requests.

Top module: `vsub_loop_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `src_step`, `dst_step` and `sub_step` become 0 after that edge.
- R2: `sub_end` is high when `vec_mode` is 1, `vec_len` is nonzero and `sub_step` equals `sub_last`, where `sub_last` is the sub-vector length minus one; otherwise it is 0.
- R3: An accepted advance (`adv`=1, `vec_mode`=1, `vec_len` nonzero) while `sub_end` is 0 increases `sub_step` by 1 and leaves both outer indices unchanged.
- R4: An accepted advance while `sub_end` is 1 and `loop_last` is 0 sets `sub_step` to 0, increases `src_step` by 1 unless `hold_src` is 1, and increases `dst_step` by 1 unless `hold_dst` is 1.
- R5: `loop_last` is high when `sub_end` is high and either `src_step` or `dst_step` equals `vec_len` minus one.
- R6: An accepted advance while `loop_last` is 1 sets all three indices to 0, whatever the hold inputs are.
- R7: When `vec_mode` is 1 and `vec_len` is 0, `skip_insn` is 1 and an advance changes no index.
- R8: With `adv` at 0, or with `vec_mode` at 0, the indices keep their values across the edge.
- R9: Starting from zero with both holds low, a full loop takes `vec_len`×(`sub_last`+1) accepted advances; `loop_last` is high only before the final one, and the indices are all 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of all indices |
| vec_mode | input | 1 | Instruction runs as a vector loop |
| vec_len | input | 7 | Number of elements in the loop |
| sub_last | input | 2 | Sub-vector length minus one, held stable during a loop |
| adv | input | 1 | Request to move to the next iteration |
| hold_src | input | 1 | Keep the source index when the outer indices step |
| hold_dst | input | 1 | Keep the destination index when the outer indices step |
| src_step | output | 7 | Current source element index |
| dst_step | output | 7 | Current destination element index |
| sub_step | output | 2 | Current sub-element index |
| sub_end | output | 1 | Sub-element index is at its bound |
| loop_last | output | 1 | Current iteration is the final one of the loop |
| skip_insn | output | 1 | Zero-length vector: instruction is to be skipped |

## Verification
The assertions check on every cycle the local stepping rules: an inner step leaves the outer indices alone, a wrap clears the inner index, a held side keeps its value, an advance on the last iteration clears everything, and a skipped or idle cycle freezes the state. What they cannot show is whether the sequence as a whole is right, such as the number of advances a complete loop takes for a given length and sub-vector bound, or that the final iteration is flagged when only the destination side has reached its end; those come from the bench's table of vectors and its directed full-loop walks.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

    parameter int STEP_W = 7;
    parameter int SUB_W  = 2;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SUB   = 2'd1,
        ACT_OUTER = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    typedef struct packed {
        logic [STEP_W-1:0] src;
        logic [STEP_W-1:0] dst;
        logic [SUB_W-1:0]  sub;
    } loop_state_t;

    function automatic logic at_tail(input logic [STEP_W-1:0] idx,
                                     input logic [STEP_W-1:0] len);
        logic [STEP_W-1:0] one;
        one = {{(STEP_W-1){1'b0}}, 1'b1};
        return (len != '0) && (idx == len - one);
    endfunction

endpackage

// File: rtl/vsl_ctrl.sv
module vsl_ctrl
    import vsl_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int UW = SUB_W
) (
    input  logic          vec_mode,
    input  logic          adv,
    input  logic [SW-1:0] vec_len,
    input  logic [UW-1:0] sub_last,
    input  loop_state_t   cur,
    output act_e          act,
    output logic          sub_end,
    output logic          loop_last,
    output logic          skip_insn
);

    logic live;
    logic tail_hit;

    always_comb begin
        skip_insn = vec_mode && (vec_len == '0);
        live      = vec_mode && !skip_insn;
        sub_end   = live && (cur.sub == sub_last);
        tail_hit  = at_tail(cur.src, vec_len) || at_tail(cur.dst, vec_len);
        loop_last = sub_end && tail_hit;
        if (!(adv && live)) begin
            act = ACT_HOLD;
        end else if (loop_last) begin
            act = ACT_CLEAR;
        end else if (sub_end) begin
            act = ACT_OUTER;
        end else begin
            act = ACT_SUB;
        end
    end

endmodule

// File: rtl/vsl_sub_ctr.sv
module vsl_sub_ctr
    import vsl_pkg::*;
#(
    parameter int UW = SUB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    output logic [UW-1:0] sub_q
);

    localparam logic [UW-1:0] ONE = {{(UW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
        end else begin
            case (act)
                ACT_SUB:   sub_q <= sub_q + ONE;
                ACT_OUTER: sub_q <= '0;
                ACT_CLEAR: sub_q <= '0;
                default:   sub_q <= sub_q;
            endcase
        end
    end

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OUTER) |=> (sub_q == '0)); // R4

endmodule

// File: rtl/vsl_outer_ctr.sv
module vsl_outer_ctr
    import vsl_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic          hold,
    output logic [SW-1:0] step_q
);

    localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else begin
            case (act)
                ACT_OUTER: step_q <= hold ? step_q : step_q + ONE;
                ACT_CLEAR: step_q <= '0;
                default:   step_q <= step_q;
            endcase
        end
    end

    AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OUTER && hold) |=> $stable(step_q)); // R4

    AST_OUTER_STEP: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OUTER && !hold) |=> (step_q == $past(step_q) + ONE)); // R4

endmodule

// File: rtl/vsub_loop_seq.sv
module vsub_loop_seq
    import vsl_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int UW = SUB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vec_mode,
    input  logic [SW-1:0] vec_len,
    input  logic [UW-1:0] sub_last,
    input  logic          adv,
    input  logic          hold_src,
    input  logic          hold_dst,
    output logic [SW-1:0] src_step,
    output logic [SW-1:0] dst_step,
    output logic [UW-1:0] sub_step,
    output logic          sub_end,
    output logic          loop_last,
    output logic          skip_insn
);

    localparam int SIDES = 2;
    localparam logic [UW-1:0] SUB_ONE = {{(UW-1){1'b0}}, 1'b1};

    act_e        act;
    loop_state_t cur;
    logic [SIDES-1:0]         side_hold;
    logic [SIDES-1:0][SW-1:0] side_step;

    assign side_hold = {hold_dst, hold_src};
    assign src_step  = side_step[0];
    assign dst_step  = side_step[1];

    always_comb begin
        cur.src = side_step[0];
        cur.dst = side_step[1];
        cur.sub = sub_step;
    end

    vsl_ctrl #(.SW(SW), .UW(UW)) u_ctrl (
        .vec_mode  (vec_mode),
        .adv       (adv),
        .vec_len   (vec_len),
        .sub_last  (sub_last),
        .cur       (cur),
        .act       (act),
        .sub_end   (sub_end),
        .loop_last (loop_last),
        .skip_insn (skip_insn)
    );

    vsl_sub_ctr #(.UW(UW)) u_sub (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .sub_q (sub_step)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        vsl_outer_ctr #(.SW(SW)) u_outer (
            .clk    (clk),
            .rst    (rst),
            .act    (act),
            .hold   (side_hold[g]),
            .step_q (side_step[g])
        );
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (src_step == '0 && dst_step == '0 && sub_step == '0)); // R1

    AST_SUB_INC: assert property (@(posedge clk) disable iff (rst)
        (adv && vec_mode && !skip_insn && !sub_end)
        |=> (sub_step == $past(sub_step) + SUB_ONE) && $stable(src_step) && $stable(dst_step)); // R3

    AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
        (adv && loop_last) |=> (src_step == '0 && dst_step == '0 && sub_step == '0)); // R6

    AST_SKIP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        skip_insn |=> $stable(src_step) && $stable(dst_step) && $stable(sub_step)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv || !vec_mode) |=> $stable(src_step) && $stable(dst_step) && $stable(sub_step)); // R8

    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (rst)
        loop_last |-> (sub_end && !skip_insn)); // R5

endmodule

// File: tb/tb_vsub_loop_seq.sv
module tb_vsub_loop_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vec_mode = 1'b0;
    logic [6:0] vec_len = '0;
    logic [1:0] sub_last = '0;
    logic       adv = 1'b0;
    logic       hold_src = 1'b0;
    logic       hold_dst = 1'b0;
    logic [6:0] src_step, dst_step;
    logic [1:0] sub_step;
    logic       sub_end, loop_last, skip_insn;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    vsub_loop_seq dut (
        .clk(clk), .rst(rst), .vec_mode(vec_mode), .vec_len(vec_len),
        .sub_last(sub_last), .adv(adv), .hold_src(hold_src), .hold_dst(hold_dst),
        .src_step(src_step), .dst_step(dst_step), .sub_step(sub_step),
        .sub_end(sub_end), .loop_last(loop_last), .skip_insn(skip_insn)
    );

    typedef struct packed {
        logic       vm;
        logic [6:0] vl;
        logic [1:0] sl;
        logic       ad;
        logic       hs;
        logic       hd;
        logic       x_end;
        logic       x_last;
        logic       x_skip;
        logic [6:0] n_src;
        logic [6:0] n_dst;
        logic [1:0] n_sub;
    } row_t;

    localparam int NROW = 13;
    localparam row_t TBL [NROW] = '{
        '{1'b1, 7'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 2'd1}, // R3
        '{1'b1, 7'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd1, 7'd1, 2'd0}, // R2 R4
        '{1'b1, 7'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd1, 7'd1, 2'd0}, // R8
        '{1'b1, 7'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd1, 7'd1, 2'd1}, // R3
        '{1'b1, 7'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'd0, 7'd0, 2'd0}, // R5 R6
        '{1'b1, 7'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0, 7'd1, 2'd0}, // R4 src held
        '{1'b0, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd1, 2'd0}, // R8 scalar
        '{1'b1, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd1, 7'd2, 2'd0}, // R4
        '{1'b1, 7'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'd2, 7'd3, 2'd0}, // R4
        '{1'b1, 7'd4, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 7'd0, 7'd0, 2'd0}, // R5 dst side, R6
        '{1'b1, 7'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 2'd1}, // R3
        '{1'b1, 7'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd0, 7'd0, 2'd1}, // R7
        '{1'b1, 7'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 2'd1}  // R8
    };

    task automatic chk(input string req, input int act_v, input int exp_v);
        tests++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic step_once(input logic a, input logic hs, input logic hd);
        @(negedge clk);
        adv = a; hold_src = hs; hold_dst = hd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        int last_seen;
        int over;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset src", int'(src_step), 0);
        chk("R1 reset dst", int'(dst_step), 0);
        chk("R1 reset sub", int'(sub_step), 0);
        rst = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            vec_mode = TBL[i].vm; vec_len = TBL[i].vl; sub_last = TBL[i].sl;
            adv = TBL[i].ad; hold_src = TBL[i].hs; hold_dst = TBL[i].hd;
            #1;
            chk($sformatf("table row %0d sub_end", i), int'(sub_end), int'(TBL[i].x_end));
            chk($sformatf("table row %0d loop_last", i), int'(loop_last), int'(TBL[i].x_last));
            chk($sformatf("table row %0d skip_insn", i), int'(skip_insn), int'(TBL[i].x_skip));
            @(posedge clk);
            #1;
            chk($sformatf("table row %0d src", i), int'(src_step), int'(TBL[i].n_src));
            chk($sformatf("table row %0d dst", i), int'(dst_step), int'(TBL[i].n_dst));
            chk($sformatf("table row %0d sub", i), int'(sub_step), int'(TBL[i].n_sub));
        end

        // R1: reset in the middle of a loop
        @(negedge clk);
        rst = 1'b1; adv = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid-loop src", int'(src_step), 0);
        chk("R1 mid-loop dst", int'(dst_step), 0);
        chk("R1 mid-loop sub", int'(sub_step), 0);
        @(negedge clk);
        rst = 1'b0; adv = 1'b0;

        // R4: destination held while source moves
        @(negedge clk);
        vec_mode = 1'b1; vec_len = 7'd5; sub_last = 2'd0;
        step_once(1'b1, 1'b0, 1'b1);
        step_once(1'b1, 1'b0, 1'b1);
        step_once(1'b0, 1'b0, 1'b0);
        #1;
        chk("R4 dst held value", int'(dst_step), 0);
        chk("R4 src moved value", int'(src_step), 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // R9 and R2: full walk, vec_len=3, sub_last=2 -> 9 advances
        vec_len = 7'd3; sub_last = 2'd2;
        cnt = 0; last_seen = 0; over = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            adv = 1'b1; hold_src = 1'b0; hold_dst = 1'b0;
            #1;
            if (sub_step > sub_last) over++;
            if (loop_last) last_seen = k + 1;
            cnt++;
            @(posedge clk); #1;
            if (loop_last == 1'b0 && src_step == 0 && dst_step == 0 && sub_step == 0) break;
        end
        chk("R9 advances for 3x3 loop", cnt, 9);
        chk("R9 last flagged on final advance", last_seen, 9);
        chk("R2 sub index within bound", over, 0);

        // R9 and R2: vec_len=1, sub_last=3 -> 4 advances, sub reaches 3
        cnt = 0; last_seen = 0; over = 0;
        @(negedge clk);
        adv = 1'b0; vec_len = 7'd1; sub_last = 2'd3;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            adv = 1'b1;
            #1;
            if (sub_end) over = int'(sub_step);
            if (loop_last) last_seen = k + 1;
            cnt++;
            @(posedge clk); #1;
            if (src_step == 0 && dst_step == 0 && sub_step == 0) break;
        end
        chk("R9 advances for 1x4 loop", cnt, 4);
        chk("R9 last on fourth advance", last_seen, 4);
        chk("R2 sub_end at index 3", over, 3);

        @(negedge clk);
        adv = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule